// File: doc/BRIEF.md
# Shared Memory Lockout Arbiter

This block sits between a small byte-wide memory and two masters: a local joint processor, which always has first claim on the memory, and a host, which reaches the memory through a byte-wide I/O path. The joint's own accesses to the memory decide whether the host may enter. An access at an even address closes the memory to the host, and the next access at an odd address opens it again. This lets the joint bracket multi-byte updates so that the host never observes half of one.

Before issuing any transfer, the host loads a joint identifier. Only the joint whose identifier matches responds. A host read or write strobe is captured as one pending request. The request waits until the memory is open and the joint signals an instruction fetch, which is a cycle in which the joint cannot touch data. The host address and control lines are then switched onto the memory for one cycle. A one-cycle done pulse reports completion, and for a read the data is left in a holding register.

The memory select seen by the joint is stretched. After a joint access made while the phase-two clock is high, the select stays asserted until that clock is seen to fall.

Top module: `shmem_lockout_arbiter`

## Requirements
- R1: After reset the lock flag, pending request, done pulse, holding register (0) and memory select are all low. The joint identifier is cleared to 0, so a host strobe is ignored until an identifier equal to JOINT_ID is loaded.
- R2: A joint access (joint_req high) at an even address (bit 0 = 0) sets bus_locked on the next clock edge.
- R3: A joint access at an odd address (bit 0 = 1) clears bus_locked on the next clock edge.
- R4: A host request made while bus_locked is high stays pending (host_wait high) and is not granted for as long as the lock holds.
- R5: host_grant is high only while a request is pending, bus_locked is low, joint_fetch is high and joint_req is low.
- R6: host_done is a single-cycle pulse two clock edges after the cycle in which host_grant is high.
- R7: Read data is loaded into host_rdata only when a granted read completes. It keeps its value across later host writes.
- R8: Host strobes that arrive while a request is pending are ignored. Only the first request reaches the memory.
- R9: Host strobes are ignored while the loaded identifier differs from JOINT_ID.
- R10: After a joint access with joint_phi2 high, mem_cs stays high until the clock edge at which joint_phi2 is seen low after having been high.
- R11: During a host grant, the memory address, write enable and data come from the host request. Otherwise they come from the joint, so each side reads what the other wrote.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| joint_req | input | 1 | Joint accesses the shared memory this cycle |
| joint_we | input | 1 | Joint access is a write |
| joint_addr | input | AW | Joint memory address |
| joint_wdata | input | DW | Joint write data |
| joint_fetch | input | 1 | Joint is fetching an instruction |
| joint_phi2 | input | 1 | Joint phase-two clock level |
| joint_rdata | output | DW | Memory read data, valid the cycle after a read |
| host_sel_load | input | 1 | Load the joint identifier |
| host_sel_id | input | SW | Joint identifier to load |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | AW | Host memory address |
| host_wdata | input | DW | Host write data |
| host_rdata | output | DW | Holding register for host read data |
| host_wait | output | 1 | Host request pending |
| host_grant | output | 1 | Host owns the memory this cycle |
| host_done | output | 1 | One-cycle completion pulse |
| bus_locked | output | 1 | Joint lock flag |
| mem_cs | output | 1 | Memory select, including the stretch |

## Verification
The bench builds the block with a 4-bit address (16 locations), a 2-bit identifier and JOINT_ID = 2. With these values every location can be swept in both directions: the joint writes each location and the host reads it back, then the host writes each location and the joint reads it back, with data computed from the address. The same small configuration makes the stall sequence cheap to walk cycle by cycle. That sequence covers the lock set by an even access, the request held while locked, the request held while unlocked but not fetching, and the grant and done timing once fetch returns. It also covers ignored strobes from an unselected or busy host, and the select stretch around a falling phase-two edge.

// File: rtl/shmem_pkg.sv
package shmem_pkg;
  // Captured host request, parameter-free widths kept at the maximum used.
  typedef struct packed {
    logic        we;
    logic [15:0] addr;
    logic [15:0] wdata;
  } host_req_t;
endpackage

// File: rtl/shmem_lock.sv
module shmem_lock #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          joint_req,
  input  logic [AW-1:0] joint_addr,
  input  logic          joint_phi2,
  output logic          locked,
  output logic          stretch
);
  logic lock_q, lock_d;
  logic phi2_q, phi2_d;
  logic str_q, str_d;
  logic phi2_fall;

  always_comb begin
    phi2_fall = phi2_q & ~joint_phi2;
    lock_d    = lock_q;
    if (joint_req) lock_d = ~joint_addr[0];
    phi2_d = joint_phi2;
    str_d  = (joint_req & joint_phi2) | (str_q & ~phi2_fall);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      phi2_q <= 1'b0;
      str_q  <= 1'b0;
    end else begin
      lock_q <= lock_d;
      phi2_q <= phi2_d;
      str_q  <= str_d;
    end
  end

  assign locked  = lock_q;
  assign stretch = str_q;
endmodule

// File: rtl/shmem_host_port.sv
module shmem_host_port
  import shmem_pkg::*;
#(
  parameter int AW       = 10,
  parameter int DW       = 8,
  parameter int SW       = 2,
  parameter int JOINT_ID = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_sel_load,
  input  logic [SW-1:0] host_sel_id,
  input  logic          host_rd,
  input  logic          host_wr,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  input  logic          locked,
  input  logic          joint_fetch,
  input  logic          joint_req,
  input  logic [DW-1:0] mem_rdata,
  output logic          grant,
  output logic [AW-1:0] req_addr,
  output logic          req_we,
  output logic [DW-1:0] req_wdata,
  output logic          wait_o,
  output logic          done,
  output logic [DW-1:0] hold
);
  localparam logic [SW-1:0] MY_ID = SW'(JOINT_ID);

  logic [SW-1:0] sel_q, sel_d;
  logic          pend_q, pend_d;
  host_req_t     req_q, req_d;
  logic          gnt_q, rdop_q, rdop_d, done_q;
  logic [DW-1:0] hold_q, hold_d;
  logic          accept;

  always_comb begin
    accept = (host_rd | host_wr) & (sel_q == MY_ID) & ~pend_q & ~gnt_q;
    grant  = pend_q & ~locked & joint_fetch & ~joint_req;
    sel_d  = host_sel_load ? host_sel_id : sel_q;
    pend_d = pend_q;
    if (accept)     pend_d = 1'b1;
    else if (grant) pend_d = 1'b0;
    req_d = req_q;
    if (accept) begin
      req_d       = '0;
      req_d.we    = host_wr;
      req_d.addr  = 16'(host_addr);
      req_d.wdata = 16'(host_wdata);
    end
    rdop_d = grant & ~req_q.we;
    hold_d = (gnt_q & rdop_q) ? mem_rdata : hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      pend_q <= 1'b0;
      req_q  <= '0;
      gnt_q  <= 1'b0;
      rdop_q <= 1'b0;
      done_q <= 1'b0;
      hold_q <= '0;
    end else begin
      sel_q  <= sel_d;
      pend_q <= pend_d;
      req_q  <= req_d;
      gnt_q  <= grant;
      rdop_q <= rdop_d;
      done_q <= gnt_q;
      hold_q <= hold_d;
    end
  end

  assign req_addr  = req_q.addr[AW-1:0];
  assign req_we    = req_q.we;
  assign req_wdata = req_q.wdata[DW-1:0];
  assign wait_o    = pend_q;
  assign done      = done_q;
  assign hold      = hold_q;
endmodule

// File: rtl/shmem_ram.sv
module shmem_ram #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      rdata <= mem[addr];
    end
  end
endmodule

// File: rtl/shmem_lockout_arbiter.sv
module shmem_lockout_arbiter #(
  parameter int AW       = 10,
  parameter int DW       = 8,
  parameter int SW       = 2,
  parameter int JOINT_ID = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          joint_req,
  input  logic          joint_we,
  input  logic [AW-1:0] joint_addr,
  input  logic [DW-1:0] joint_wdata,
  input  logic          joint_fetch,
  input  logic          joint_phi2,
  output logic [DW-1:0] joint_rdata,
  input  logic          host_sel_load,
  input  logic [SW-1:0] host_sel_id,
  input  logic          host_rd,
  input  logic          host_wr,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  output logic          host_wait,
  output logic          host_grant,
  output logic          host_done,
  output logic          bus_locked,
  output logic          mem_cs
);
  // Reset asserts at once, releases on the clock.
  logic [1:0] rst_sync;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  logic          locked, stretch, grant;
  logic [AW-1:0] req_addr, m_addr;
  logic          req_we, m_we, m_en;
  logic [DW-1:0] req_wdata, m_wdata, m_rdata;

  shmem_lock #(.AW(AW)) u_lock (
    .clk(clk), .rst_n(rst_int_n), .joint_req(joint_req),
    .joint_addr(joint_addr), .joint_phi2(joint_phi2),
    .locked(locked), .stretch(stretch)
  );

  shmem_host_port #(.AW(AW), .DW(DW), .SW(SW), .JOINT_ID(JOINT_ID)) u_host (
    .clk(clk), .rst_n(rst_int_n), .host_sel_load(host_sel_load),
    .host_sel_id(host_sel_id), .host_rd(host_rd), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .locked(locked),
    .joint_fetch(joint_fetch), .joint_req(joint_req), .mem_rdata(m_rdata),
    .grant(grant), .req_addr(req_addr), .req_we(req_we),
    .req_wdata(req_wdata), .wait_o(host_wait), .done(host_done),
    .hold(host_rdata)
  );

  // 2:1 steering of address, write enable, data and select.
  always_comb begin
    m_en    = grant | joint_req;
    m_addr  = grant ? req_addr  : joint_addr;
    m_we    = grant ? req_we    : (joint_req & joint_we);
    m_wdata = grant ? req_wdata : joint_wdata;
  end

  shmem_ram #(.AW(AW), .DW(DW)) u_ram (
    .clk(clk), .en(m_en), .we(m_we), .addr(m_addr),
    .wdata(m_wdata), .rdata(m_rdata)
  );

  assign joint_rdata = m_rdata;
  assign host_grant  = grant;
  assign bus_locked  = locked;
  assign mem_cs      = m_en | stretch;
endmodule

// File: rtl/shmem_lockout_checker.sv
module shmem_lockout_checker #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          joint_req,
  input logic [AW-1:0] joint_addr,
  input logic          joint_fetch,
  input logic          joint_phi2,
  input logic          host_wait,
  input logic          host_grant,
  input logic          host_done,
  input logic [DW-1:0] host_rdata,
  input logic          bus_locked,
  input logic          mem_cs
);
  a_r2_even_locks: assert property (@(posedge clk) disable iff (!rst_n)
    joint_req && !joint_addr[0] |=> bus_locked);
  a_r3_odd_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
    joint_req && joint_addr[0] |=> !bus_locked);
  a_r4_no_grant_locked: assert property (@(posedge clk) disable iff (!rst_n)
    bus_locked |-> !host_grant);
  a_r5_grant_conditions: assert property (@(posedge clk) disable iff (!rst_n)
    host_grant |-> host_wait && joint_fetch && !joint_req);
  a_r6_done_timing: assert property (@(posedge clk) disable iff (!rst_n)
    host_grant |-> ##2 host_done);
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    host_done |=> !host_done);
  a_r7_hold_only_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(host_rdata) |-> host_done);
  a_r8_pending_held: assert property (@(posedge clk) disable iff (!rst_n)
    host_wait && !host_grant |=> host_wait);
  a_r10_cs_stretch: assert property (@(posedge clk) disable iff (!rst_n)
    joint_req && joint_phi2 |=> mem_cs);
endmodule

bind shmem_lockout_arbiter shmem_lockout_checker #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_int_n), .joint_req(joint_req),
  .joint_addr(joint_addr), .joint_fetch(joint_fetch),
  .joint_phi2(joint_phi2), .host_wait(host_wait), .host_grant(host_grant),
  .host_done(host_done), .host_rdata(host_rdata),
  .bus_locked(bus_locked), .mem_cs(mem_cs)
);

// File: tb/test_shmem_lockout_arbiter.sv
`timescale 1ns/1ps
module test_shmem_lockout_arbiter;
  localparam int AW = 4, DW = 8, SW = 2, JID = 2;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n;
  logic joint_req, joint_we, joint_fetch, joint_phi2;
  logic [AW-1:0] joint_addr, host_addr;
  logic [DW-1:0] joint_wdata, joint_rdata, host_wdata, host_rdata;
  logic host_sel_load, host_rd, host_wr;
  logic [SW-1:0] host_sel_id;
  logic host_wait, host_grant, host_done, bus_locked, mem_cs;

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  shmem_lockout_arbiter #(.AW(AW), .DW(DW), .SW(SW), .JOINT_ID(JID)) i_shmem_lockout_arbiter (
    .clk(clk), .rst_n(rst_n), .joint_req(joint_req), .joint_we(joint_we),
    .joint_addr(joint_addr), .joint_wdata(joint_wdata),
    .joint_fetch(joint_fetch), .joint_phi2(joint_phi2),
    .joint_rdata(joint_rdata), .host_sel_load(host_sel_load),
    .host_sel_id(host_sel_id), .host_rd(host_rd), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_wait(host_wait), .host_grant(host_grant), .host_done(host_done),
    .bus_locked(bus_locked), .mem_cs(mem_cs)
  );

  function automatic logic [7:0] jpat(input int a);
    return 8'((a * 37 + 5) & 255);
  endfunction
  function automatic logic [7:0] hpat(input int a);
    return 8'(((a * 3) ^ 8'hA5) & 255);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic joint_op(input bit we, input int a, input logic [7:0] d);
    @(negedge clk);
    joint_req = 1'b1; joint_we = we; joint_addr = AW'(a); joint_wdata = d;
    @(negedge clk);
    joint_req = 1'b0; joint_we = 1'b0;
  endtask

  task automatic host_op(input bit wr, input int a, input logic [7:0] d, output bit ok);
    @(negedge clk);
    host_rd = !wr; host_wr = wr; host_addr = AW'(a); host_wdata = d;
    @(negedge clk);
    host_rd = 1'b0; host_wr = 1'b0;
    ok = 1'b0;
    for (int i = 0; i < 50; i++) begin
      if (host_done) begin ok = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  task automatic select(input int id);
    @(negedge clk);
    host_sel_load = 1'b1; host_sel_id = SW'(id);
    @(negedge clk);
    host_sel_load = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit ok;
    joint_req = 0; joint_we = 0; joint_addr = '0; joint_wdata = '0;
    joint_fetch = 1; joint_phi2 = 0; host_sel_load = 0; host_sel_id = '0;
    host_rd = 0; host_wr = 0; host_addr = '0; host_wdata = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1: reset state
    check(!bus_locked, "R1 lock", bus_locked, 0);
    check(!host_wait && !host_done, "R1 pend/done", {host_wait, host_done}, 0);
    check(host_rdata == 0, "R1 hold", host_rdata, 0);
    check(!mem_cs, "R1 cs", mem_cs, 0);
    // R1/R9: identifier cleared, strobe ignored
    @(negedge clk); host_wr = 1; host_addr = 0; host_wdata = 8'h77;
    @(negedge clk); host_wr = 0;
    repeat (4) begin
      check(!host_wait && !host_done, "R1 unselected strobe", host_wait, 0);
      @(negedge clk);
    end

    select(JID);
    // R11: joint writes every location, host reads each back (odd last -> unlocked)
    for (int a = 0; a < DEPTH; a++) joint_op(1, a, jpat(a));
    joint_op(0, 1, 8'h00);
    for (int a = 0; a < DEPTH; a++) begin
      host_op(0, a, 8'h00, ok);
      check(ok, "R6 done seen", ok, 1);
      check(host_rdata == jpat(a), "R11 host read", host_rdata, jpat(a));
    end
    // R11: host writes every location, joint reads back
    for (int a = 0; a < DEPTH; a++) begin
      host_op(1, a, hpat(a), ok);
      check(ok, "R6 done seen", ok, 1);
    end
    // R7: hold unchanged by writes
    check(host_rdata == jpat(DEPTH-1), "R7 hold after writes", host_rdata, jpat(DEPTH-1));
    for (int a = 0; a < DEPTH; a += 2) begin
      joint_op(0, a + 1, 8'h00);
      check(joint_rdata == hpat(a + 1), "R11 joint read", joint_rdata, hpat(a + 1));
      joint_op(0, a, 8'h00);
      check(joint_rdata == hpat(a), "R11 joint read", joint_rdata, hpat(a));
      check(bus_locked, "R2 even locks", bus_locked, 1);
      joint_op(0, 1, 8'h00);
      check(!bus_locked, "R3 odd unlocks", bus_locked, 0);
    end

    // R4/R5/R6: stall sequence
    joint_op(0, 2, 8'h00);
    check(bus_locked, "R2 lock before stall", bus_locked, 1);
    @(negedge clk); host_rd = 1; host_addr = 6;
    @(negedge clk); host_rd = 0;
    // R8: second strobe while pending, to another address
    host_wr = 1; host_addr = 7; host_wdata = 8'h22;
    @(negedge clk); host_wr = 0;
    for (int i = 0; i < 6; i++) begin
      check(host_wait && !host_grant && !host_done, "R4 stalled", {host_wait, host_grant, host_done}, 4);
      @(negedge clk);
    end
    joint_fetch = 0;
    joint_op(0, 3, 8'h00);
    check(!bus_locked, "R3 unlocked", bus_locked, 0);
    check(!host_grant && host_wait, "R5 no fetch no grant", host_grant, 0);
    @(negedge clk);
    check(!host_grant, "R5 no fetch no grant", host_grant, 0);
    joint_fetch = 1;
    #1;
    check(host_grant, "R5 grant on fetch", host_grant, 1);
    @(negedge clk);
    check(!host_done && !host_wait, "R6 not yet done", host_done, 0);
    @(negedge clk);
    check(host_done, "R6 done two edges after grant", host_done, 1);
    check(host_rdata == hpat(6), "R7 read data", host_rdata, hpat(6));
    @(negedge clk);
    check(!host_done, "R6 single pulse", host_done, 0);
    check(!host_wait, "R8 second strobe dropped", host_wait, 0);
    joint_op(0, 7, 8'h00);
    check(joint_rdata == hpat(7), "R8 location untouched", joint_rdata, hpat(7));

    // R9: wrong identifier
    select(1);
    @(negedge clk); host_wr = 1; host_addr = 5; host_wdata = 8'h5A;
    @(negedge clk); host_wr = 0;
    for (int i = 0; i < 4; i++) begin
      check(!host_wait && !host_done, "R9 unselected", host_wait, 0);
      @(negedge clk);
    end
    joint_op(0, 5, 8'h00);
    check(joint_rdata == hpat(5), "R9 memory unchanged", joint_rdata, hpat(5));
    select(JID);

    // R10: select stretch
    @(negedge clk);
    check(!mem_cs, "R10 idle cs", mem_cs, 0);
    joint_phi2 = 1;
    joint_op(0, 1, 8'h00);
    for (int i = 0; i < 3; i++) begin
      check(mem_cs, "R10 cs stretched", mem_cs, 1);
      @(negedge clk);
    end
    joint_phi2 = 0;
    @(negedge clk);
    check(!mem_cs, "R10 cs released after fall", mem_cs, 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule